// File: doc/BRIEF.md
# Triggered Multi-Buffer Frame Capture

This block sits between a free-running pixel sensor and a downstream readout link. The sensor emits an endless stream of zero-suppressed hit addresses, each a row and column pair on a 1088-row by 1024-column array. The stream has no frame header. The block finds frame edges from the order of the addresses. A hit whose row is lower than the row of the hit before it opens a new frame.

An external trigger claims one of several independent event buffers. That buffer waits for the next frame edge, stores exactly one whole frame and then becomes complete. Triggers meet no dead time while any buffer is free. A trigger that finds every buffer taken is dropped and counted.

Complete buffers drain over a ready/valid port in the order of their triggers. Each event goes out as a header word carrying the trigger number, then the stored hits, then a trailer word carrying the hit count and an overflow flag. The block is meant for the readout clock domain, which runs at 160 MHz. It is sized for about 250 to 350 hits per frame at a trigger rate near 1 kHz.

Top module: `trig_frame_capture`

## Requirements
- R1: A synchronous reset makes every buffer free and clears the dropped-trigger counter and the trigger numbering. After reset, out_valid, busy and drop_count are all 0, and the first trigger is numbered 0.
- R2: A frame edge is a valid hit whose row is strictly lower than the row of the previous valid hit. The previous row is 0 after reset, so the first hit after reset is never an edge.
- R3: An accepted trigger arms one free buffer. Capture starts at the first frame edge in a later cycle. A trigger in the same cycle as an edge hit waits for the following edge. The stored hits run from the edge hit up to, but not including, the next edge hit.
- R4: Each output word is 23 bits, with the tag in bits [22:21]. A header is tag 01 with the trigger number in [15:0]. A hit is tag 00 with the row in [20:10] and the column in [9:0]. A trailer is tag 10 with the overflow flag in bit 10 and the stored hit count in [9:0]. All other bits are 0.
- R5: The trigger number of an event is the number of trigger cycles seen since reset before its own, counted modulo 2^16. Dropped triggers are included in that count.
- R6: A trigger is accepted whenever at least one buffer is free, including on consecutive cycles. Triggers armed during the same frame all capture the same next frame.
- R7: A trigger in a cycle when all buffers are occupied is not captured. It raises busy in that same cycle and increments drop_count, which saturates at 65535.
- R8: A buffer holds at most 512 hits. Further hits of that frame are discarded, the trailer count reads 512 and the overflow flag is 1.
- R9: Events are delivered strictly in the order of their triggers.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold their values in the next cycle.
- R11: A drained buffer becomes free in the cycle after its trailer is accepted. A trigger in the trailer cycle is dropped when all buffers were full. A trigger in the following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | A hit address is present |
| hit_row | input | 11 | Row address of the hit |
| hit_col | input | 10 | Column address of the hit |
| trig | input | 1 | External trigger, one cycle per trigger |
| busy | output | 1 | Trigger in this cycle dropped, no free buffer |
| drop_count | output | 16 | Saturating count of dropped triggers |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 23 | Header, hit or trailer word |

## Verification
The bench feeds frames whose rows climb from 0. It places triggers in three positions: after a frame has ended, in the middle of a frame, and on the very hit that opens a frame. Comparing these shows whether capture begins at the edge after the trigger or one edge too early. Two triggers on consecutive cycles, and several triggers inside one frame, show whether sharing a frame and keeping trigger order work together. A frame longer than a buffer exercises the overflow path. With the output stalled, a burst of triggers fills every buffer and then keeps the dropped-trigger counter going up to its limit. A readout paced one word per cycle, with a trigger placed on the trailer cycle and on the cycle after it, pins down exactly when a buffer is released.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
   typedef enum logic [1:0] {
      BS_FREE  = 2'd0,
      BS_ARMED = 2'd1,
      BS_FILL  = 2'd2,
      BS_DONE  = 2'd3
   } buf_state_e;

   typedef enum logic [1:0] {
      DR_HDR  = 2'd0,
      DR_DATA = 2'd1,
      DR_TRL  = 2'd2
   } drain_phase_e;

   localparam logic [1:0] TAG_HIT = 2'b00;
   localparam logic [1:0] TAG_HDR = 2'b01;
   localparam logic [1:0] TAG_TRL = 2'b10;
endpackage

// File: rtl/fcb_edge_detect.sv
module fcb_edge_detect #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit_vld_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             edge_o
);
   logic [ROW_W-1:0] prev_row_q;

   always_ff @(posedge clk) begin
      if (rst)            prev_row_q <= '0;
      else if (hit_vld_i) prev_row_q <= row_i;
   end

   assign edge_o = hit_vld_i && (row_i < prev_row_q);

   // R2: an edge never coincides with a non-decreasing row
   a_r2_edge_on_wrap: assert property (@(posedge clk) disable iff (rst)
      hit_vld_i && $past(hit_vld_i) && (row_i >= $past(row_i)) |-> !edge_o);
endmodule

// File: rtl/fcb_event_buf.sv
module fcb_event_buf
   import fcb_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter int HIT_W  = 21,
   parameter int TRIG_W = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arm_i,
   input  logic [TRIG_W-1:0] trig_num_i,
   input  logic              hit_vld_i,
   input  logic              edge_i,
   input  logic [HIT_W-1:0]  hit_i,
   input  logic [AW-1:0]     rd_addr_i,
   input  logic              release_i,
   output buf_state_e        state_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              ovf_o,
   output logic [TRIG_W-1:0] trig_num_o,
   output logic [HIT_W-1:0]  rd_word_o
);
   logic [HIT_W-1:0] mem [DEPTH];
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic             room;

   assign room    = count_o < CNT_W'(DEPTH);
   assign wr_en   = hit_vld_i &&
                    (((state_o == BS_ARMED) && edge_i) ||
                     ((state_o == BS_FILL) && !edge_i && room));
   assign wr_addr = (state_o == BS_ARMED) ? '0 : count_o[AW-1:0];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= hit_i;
   end

   assign rd_word_o = mem[rd_addr_i];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_o    <= BS_FREE;
         count_o    <= '0;
         ovf_o      <= 1'b0;
         trig_num_o <= '0;
      end else begin
         unique case (state_o)
            BS_FREE: if (arm_i) begin
               state_o    <= BS_ARMED;
               trig_num_o <= trig_num_i;
               count_o    <= '0;
               ovf_o      <= 1'b0;
            end
            BS_ARMED: if (hit_vld_i && edge_i) begin
               state_o <= BS_FILL;
               count_o <= CNT_W'(1);
            end
            BS_FILL: if (hit_vld_i) begin
               if (edge_i)    state_o <= BS_DONE;
               else if (room) count_o <= count_o + CNT_W'(1);
               else           ovf_o   <= 1'b1;
            end
            BS_DONE: if (release_i) state_o <= BS_FREE;
            default: state_o <= BS_FREE;
         endcase
      end
   end

   // R6: arming only ever targets a free buffer
   a_r6_arm_free: assert property (@(posedge clk) disable iff (rst)
      arm_i |-> state_o == BS_FREE);
   // R8: stored count never passes the capacity
   a_r8_count_cap: assert property (@(posedge clk) disable iff (rst)
      count_o <= CNT_W'(DEPTH));
   // R11: only a complete buffer is released
   a_r11_release_done: assert property (@(posedge clk) disable iff (rst)
      release_i |-> state_o == BS_DONE);
endmodule

// File: rtl/fcb_drain.sv
module fcb_drain
   import fcb_pkg::*;
#(
   parameter int NBUF   = 4,
   parameter int DEPTH  = 512,
   parameter int HIT_W  = 21,
   parameter int TRIG_W = 16,
   parameter int PAY_W  = 21,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PW    = $clog2(NBUF)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              ovf_i,
   input  logic [TRIG_W-1:0] trig_num_i,
   input  logic [HIT_W-1:0]  word_i,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [PAY_W+1:0]  out_data,
   output logic [AW-1:0]     rd_addr_o,
   output logic [PW-1:0]     rd_ptr_o,
   output logic              release_o
);
   drain_phase_e phase_q;
   logic         fire;

   assign out_valid = (phase_q == DR_HDR) ? done_i : 1'b1;
   assign fire      = out_valid && out_ready;
   assign release_o = (phase_q == DR_TRL) && fire;

   always_comb begin
      unique case (phase_q)
         DR_HDR:  out_data = {TAG_HDR, PAY_W'(trig_num_i)};
         DR_DATA: out_data = {TAG_HIT, PAY_W'(word_i)};
         default: out_data = {TAG_TRL, PAY_W'({ovf_i, count_i})};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q   <= DR_HDR;
         rd_addr_o <= '0;
         rd_ptr_o  <= '0;
      end else if (fire) begin
         unique case (phase_q)
            DR_HDR: begin
               rd_addr_o <= '0;
               phase_q   <= (count_i == '0) ? DR_TRL : DR_DATA;
            end
            DR_DATA: begin
               if (CNT_W'(rd_addr_o) + CNT_W'(1) == count_i) phase_q <= DR_TRL;
               else rd_addr_o <= rd_addr_o + AW'(1);
            end
            default: begin
               phase_q  <= DR_HDR;
               rd_ptr_o <= rd_ptr_o + PW'(1);
            end
         endcase
      end
   end

   // R10: a stalled word is held unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   // R9: the drained buffer advances only after a trailer handshake
   a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
      rd_ptr_o != $past(rd_ptr_o) |-> $past(release_o));
endmodule

// File: rtl/trig_frame_capture.sv
module trig_frame_capture
   import fcb_pkg::*;
#(
   parameter int NBUF    = 4,
   parameter int DEPTH   = 512,
   parameter int ROW_W   = 11,
   parameter int COL_W   = 10,
   parameter int TRIG_W  = 16,
   parameter int DROP_W  = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int HIT_W  = ROW_W + COL_W,
   localparam int PAY_A  = (HIT_W > TRIG_W) ? HIT_W : TRIG_W,
   localparam int PAY_W  = (PAY_A > CNT_W + 1) ? PAY_A : CNT_W + 1,
   localparam int WORD_W = PAY_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit_valid,
   input  logic [ROW_W-1:0]  hit_row,
   input  logic [COL_W-1:0]  hit_col,
   input  logic              trig,
   output logic              busy,
   output logic [DROP_W-1:0] drop_count,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   localparam int AW  = $clog2(DEPTH);
   localparam int PW  = $clog2(NBUF);
   localparam int OCW = $clog2(NBUF + 1);

   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0)
      $error("NBUF must be a power of two of at least 2");
   if (DEPTH < 2)
      $error("DEPTH must be at least 2");

   logic              edge_hit;
   logic [PW-1:0]     wr_ptr_q;
   logic [PW-1:0]     rd_ptr;
   logic [OCW-1:0]    occ_q;
   logic [TRIG_W-1:0] trig_cnt_q;
   logic              accept;
   logic              release_w;
   logic [AW-1:0]     rd_addr;
   logic [HIT_W-1:0]  hit_word;

   buf_state_e        st_a  [NBUF];
   logic [CNT_W-1:0]  cnt_a [NBUF];
   logic [TRIG_W-1:0] tn_a  [NBUF];
   logic [HIT_W-1:0]  wd_a  [NBUF];
   logic [NBUF-1:0]   ovf_a;
   logic [NBUF-1:0]   rel_a;
   logic [NBUF-1:0]   arm_a;

   assign hit_word = {hit_row, hit_col};
   assign busy     = trig && (occ_q == OCW'(NBUF));
   assign accept   = trig && (occ_q != OCW'(NBUF));

   fcb_edge_detect #(.ROW_W(ROW_W)) edge_i (
      .clk(clk), .rst(rst), .hit_vld_i(hit_valid), .row_i(hit_row), .edge_o(edge_hit)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      assign arm_a[g] = accept && (wr_ptr_q == PW'(g));
      assign rel_a[g] = release_w && (rd_ptr == PW'(g));
      fcb_event_buf #(.DEPTH(DEPTH), .HIT_W(HIT_W), .TRIG_W(TRIG_W)) buf_i (
         .clk(clk), .rst(rst), .arm_i(arm_a[g]), .trig_num_i(trig_cnt_q),
         .hit_vld_i(hit_valid), .edge_i(edge_hit), .hit_i(hit_word),
         .rd_addr_i(rd_addr), .release_i(rel_a[g]), .state_o(st_a[g]),
         .count_o(cnt_a[g]), .ovf_o(ovf_a[g]), .trig_num_o(tn_a[g]),
         .rd_word_o(wd_a[g])
      );
   end

   fcb_drain #(.NBUF(NBUF), .DEPTH(DEPTH), .HIT_W(HIT_W), .TRIG_W(TRIG_W),
               .PAY_W(PAY_W)) drain_i (
      .clk(clk), .rst(rst), .done_i(st_a[rd_ptr] == BS_DONE),
      .count_i(cnt_a[rd_ptr]), .ovf_i(ovf_a[rd_ptr]), .trig_num_i(tn_a[rd_ptr]),
      .word_i(wd_a[rd_ptr]), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .rd_addr_o(rd_addr), .rd_ptr_o(rd_ptr),
      .release_o(release_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q   <= '0;
         occ_q      <= '0;
         trig_cnt_q <= '0;
         drop_count <= '0;
      end else begin
         if (trig)   trig_cnt_q <= trig_cnt_q + TRIG_W'(1);
         if (accept) wr_ptr_q   <= wr_ptr_q + PW'(1);
         if (busy && drop_count != '1) drop_count <= drop_count + DROP_W'(1);
         unique case ({accept, release_w})
            2'b10:   occ_q <= occ_q + OCW'(1);
            2'b01:   occ_q <= occ_q - OCW'(1);
            default: occ_q <= occ_q;
         endcase
      end
   end

   // R7: busy only answers a trigger
   a_r7_busy_trig: assert property (@(posedge clk) disable iff (rst)
      busy |-> trig);
   // R7: the drop counter never goes down
   a_r7_drop_mono: assert property (@(posedge clk) disable iff (rst)
      drop_count >= $past(drop_count));
   // R6: occupancy stays within the buffer pool
   a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
      occ_q <= OCW'(NBUF));
   // R1: nothing is offered right after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $past(rst) |-> !out_valid && drop_count == '0);
endmodule

// File: tb/trig_frame_capture_tb_top.sv
module trig_frame_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hit_valid = 1'b0;
   logic [10:0] hit_row = '0;
   logic [9:0]  hit_col = '0;
   logic        trig = 1'b0;
   logic        busy;
   logic [15:0] drop_count;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [22:0] out_data;

   always #10 clk = ~clk;

   trig_frame_capture dut_i (
      .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_row(hit_row),
      .hit_col(hit_col), .trig(trig), .busy(busy), .drop_count(drop_count),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int          total = 0;
   int          bad = 0;
   bit          finished = 0;
   logic [15:0] trig_seen = '0;
   logic [22:0] got[$];
   logic [22:0] expq[$];
   logic        stall_q = 1'b0;
   logic [22:0] data_q = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // collector with R10 hold check
   always @(negedge clk) begin
      if (rst) stall_q = 1'b0;
      else begin
         if (stall_q) chk(out_valid && out_data == data_q, "R10 stalled word held",
                          {8'b0, out_valid, out_data}, {9'h1, data_q});
         if (out_valid && out_ready) got.push_back(out_data);
         stall_q = out_valid && !out_ready;
         data_q  = out_data;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1; hit_valid = 0; trig = 0; out_ready = 0;
      repeat (3) step();
      rst = 1'b0;
      got.delete(); expq.delete();
      trig_seen = '0;
   endtask

   task automatic send_frame(input int n, input int base, input int trig_at);
      for (int i = 0; i < n; i++) begin
         hit_valid = 1'b1;
         hit_row   = 11'(i);
         hit_col   = 10'((base + i) % 1024);
         trig      = (i == trig_at);
         if (i == trig_at) trig_seen++;
         step();
      end
      hit_valid = 1'b0;
      trig = 1'b0;
   endtask

   task automatic pulse_trig();
      trig = 1'b1;
      trig_seen++;
      step();
      trig = 1'b0;
   endtask

   task automatic exp_event(input logic [15:0] tn, input int n, input int base);
      int kept = (n > 512) ? 512 : n;
      expq.push_back({2'b01, 5'b0, tn});
      for (int i = 0; i < kept; i++)
         expq.push_back({2'b00, 11'(i), 10'((base + i) % 1024)});
      expq.push_back({2'b10, 10'b0, (n > 512), 10'(kept)});
   endtask

   task automatic drain_cmp(input bit slow, input string req);
      for (int k = 0; k < 4000 && got.size() < expq.size(); k++) begin
         out_ready = slow ? k[0] : 1'b1;
         step();
      end
      out_ready = 1'b0;
      step();
      chk(got.size() == expq.size(), {req, " word count"}, got.size(), expq.size());
      for (int i = 0; i < expq.size() && i < got.size(); i++)
         chk(got[i] == expq[i], req, got[i], expq[i]);
      got.delete(); expq.delete();
   endtask

   // R1 reset state
   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
      chk(busy == 0, "R1 busy after reset", busy, 0);
      chk(drop_count == 0, "R1 drop_count after reset", drop_count, 0);
      step();
   endtask

   // R2 R3 R4 R5 R6 R9: placement of triggers against frame edges
   task automatic t_placement();
      do_reset();
      out_ready = 1'b1;
      send_frame(5, 100, -1);     // first hit after reset is no edge
      pulse_trig();               // trig 0 captures B
      send_frame(4, 200, -1);     // B
      send_frame(3, 300, -1);     // C ends B
      pulse_trig();               // trig 1
      pulse_trig();               // trig 2, back to back
      send_frame(4, 400, 2);      // D captured by 1 and 2; trig 3 mid-frame
      send_frame(3, 500, -1);     // E captured by 3
      send_frame(2, 600, -1);     // F ends E
      send_frame(3, 700, 0);      // G: trig 4 on the edge hit waits
      send_frame(3, 800, -1);     // H captured by 4
      send_frame(2, 900, -1);     // I ends H
      exp_event(16'd0, 4, 200);
      exp_event(16'd1, 4, 400);
      exp_event(16'd2, 4, 400);
      exp_event(16'd3, 3, 500);
      exp_event(16'd4, 3, 800);
      drain_cmp(1'b0, "R3 R5 R6 R9 event stream");
   endtask

   // R8 R10: oversize frame drained with a stalling sink
   task automatic t_overflow();
      do_reset();
      send_frame(2, 10, -1);
      pulse_trig();
      send_frame(520, 20, -1);
      send_frame(2, 30, -1);
      exp_event(16'd0, 520, 20);
      drain_cmp(1'b1, "R8 R10 overflow event");
   endtask

   // R7 R11: full pool, drop, release timing
   task automatic t_full_release();
      do_reset();
      send_frame(3, 40, -1);
      for (int i = 0; i < 4; i++) pulse_trig();   // trig 0..3
      trig = 1'b1; trig_seen++;                   // trig 4 dropped
      @(negedge clk);
      chk(busy == 1, "R7 busy when pool full", busy, 1);
      step();
      trig = 1'b0;
      @(negedge clk);
      chk(drop_count == 1, "R7 drop counted", drop_count, 1);
      step();
      send_frame(3, 50, -1);      // J into all four
      send_frame(2, 60, -1);      // K ends J
      repeat (2) step();
      for (int k = 1; k <= 5; k++) begin
         out_ready = 1'b1;
         trig = (k == 5);
         if (k == 5) trig_seen++;
         @(negedge clk);
         if (k == 5) chk(busy == 1, "R11 trailer cycle still full", busy, 1);
         step();
      end
      out_ready = 1'b0;
      trig = 1'b1; trig_seen++;   // trig 6 accepted
      @(negedge clk);
      chk(busy == 0, "R11 buffer free after trailer", busy, 0);
      step();
      trig = 1'b0;
      @(negedge clk);
      chk(drop_count == 2, "R11 only trailer-cycle trigger dropped", drop_count, 2);
      step();
      send_frame(2, 70, -1);      // L for trig 6
      send_frame(2, 80, -1);      // M ends L
      exp_event(16'd0, 3, 50);
      exp_event(16'd1, 3, 50);
      exp_event(16'd2, 3, 50);
      exp_event(16'd3, 3, 50);
      exp_event(16'd6, 2, 70);
      drain_cmp(1'b0, "R9 R11 order after release");
   endtask

   // R7 saturation
   task automatic t_saturate();
      do_reset();
      trig = 1'b1;
      repeat (4 + 65540) step();
      trig = 1'b0;
      @(negedge clk);
      chk(drop_count == 16'hFFFF, "R7 drop_count saturates", drop_count, 16'hFFFF);
      chk(busy == 0, "R7 busy low without trigger", busy, 0);
      step();
   endtask

   initial begin
      t_reset();
      t_placement();
      t_overflow();
      t_full_release();
      t_saturate();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule